// File: doc/BRIEF.md
# Eager-Forward Flit Validity Checker

This block sits at one input of a 2D mesh switch that supports speculative forwarding along pre-configured fast paths. Every arriving flit is classified in the same cycle: either it is a legitimate flit that must be kept and queued toward its next hop, or it is a dead copy that a neighbour pushed here speculatively and that must be dropped. For kept flits the block also computes the dimension-order output (X first, then Y) and raises a strobe for the crosspoint FIFO that feeds that output.

The decision uses only the local switch coordinates, the port the flit came in on, whether it arrived over a fast path, and the destination carried in the flit. The coordinates of the upstream switch are reconstructed from the arrival port. A speculatively forwarded flit is kept if the hop it took reduced its distance to the destination in X or in Y. A separate mask names the outputs that this input already reaches over fast paths; those outputs receive no FIFO write, because the flit has already left that way.

Top module: `eager_fwd_checker`

## Requirements
- R1: The output port follows XY order on the destination at flit bits [34:32] (X) and [37:35] (Y): east (code 1) if destination X is larger than local X, west (code 2) if smaller; otherwise north (code 3) if destination Y is larger, south (code 4) if smaller; otherwise local (code 0).
- R2: A valid flit that did not arrive over a fast path is kept, unless R5 applies.
- R3: A valid flit that arrived over a fast path is kept when its distance to the destination in X or in Y is smaller at this switch than at the upstream switch, where the upstream switch sits at X+1 for arrival port east, X-1 for west, Y+1 for north, Y-1 for south, and at this switch for local.
- R4: A valid fast-path flit that shortened neither distance is dropped, and writes no FIFO.
- R5: A flit whose computed output equals its arrival port is dropped.
- R6: The enqueue vector has at most one bit set: bit P is set exactly when the flit is valid and kept, its output is P, and bit P of the fast-path mask is clear.
- R7: When the input is not valid, keep, drop and every enqueue bit are low.
- R8: Drop is high exactly when the input is valid and the flit is not kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | A flit is present on the input |
| in_flit | input | 39 | Flit: payload [31:0], destination X [34:32], destination Y [37:35], last flag [38] |
| in_port | input | 3 | Arrival port code (0 local, 1 east, 2 west, 3 north, 4 south) |
| in_fast | input | 1 | Flit arrived over a pre-configured fast path |
| fast_mask | input | 5 | Outputs this input already reaches over fast paths, one bit per port code |
| here_x | input | 3 | X coordinate of this switch |
| here_y | input | 3 | Y coordinate of this switch |
| keep | output | 1 | Flit is valid and accepted |
| drop | output | 1 | Flit is valid and discarded |
| out_port | output | 3 | Dimension-order output port code |
| enq | output | 5 | Write strobe for the crosspoint FIFO of each output |

## Verification
Every destination in an 8x8 grid is applied from every arrival port, with and without the fast-path flag, at a corner switch, an interior switch and the opposite corner; the corners separate the upstream reconstruction from wrap-around mistakes at the mesh edge. Fast-path flits that approach in one axis, in both, or in none tell the either-axis acceptance apart from an both-axes or X-only rule, and destinations equal to the local position or lying behind the arrival port exercise the turn-back drop. Varying fast-path masks over the sweep show that a masked output suppresses the FIFO write while the keep decision is unchanged, and an idle pass with the valid flag low confirms that nothing leaks out.

// File: rtl/efv_pkg.sv
package efv_pkg;
  localparam int PORT_W = 3;
  localparam int NPORTS = 5;

  typedef enum logic [PORT_W-1:0] {
    P_LOCAL = 3'd0,
    P_EAST  = 3'd1,
    P_WEST  = 3'd2,
    P_NORTH = 3'd3,
    P_SOUTH = 3'd4
  } port_e;
endpackage

// File: rtl/efv_xy_route.sv
module efv_xy_route
  import efv_pkg::*;
#(
  parameter int COORD_W = 3
) (
  input  logic [COORD_W-1:0] here_x,
  input  logic [COORD_W-1:0] here_y,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  output port_e              route
);
  always_comb begin
    if (dst_x > here_x)      route = P_EAST;
    else if (dst_x < here_x) route = P_WEST;
    else if (dst_y > here_y) route = P_NORTH;
    else if (dst_y < here_y) route = P_SOUTH;
    else                     route = P_LOCAL;
  end
endmodule

// File: rtl/efv_progress.sv
module efv_progress
  import efv_pkg::*;
#(
  parameter int COORD_W = 3
) (
  input  logic [COORD_W-1:0] here_x,
  input  logic [COORD_W-1:0] here_y,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  input  logic [PORT_W-1:0]  arr_port,
  output logic               approached
);
  localparam int SW = COORD_W + 2;

  function automatic logic signed [SW-1:0] absdiff(
    input logic signed [SW-1:0] a,
    input logic signed [SW-1:0] b
  );
    logic signed [SW-1:0] d;
    d = a - b;
    return (d < 0) ? -d : d;
  endfunction

  logic signed [SW-1:0] hx, hy, tx, ty, ux, uy, step_x, step_y;
  logic signed [SW-1:0] dist_here_x, dist_here_y, dist_up_x, dist_up_y;

  always_comb begin
    step_x = '0;
    step_y = '0;
    case (arr_port)
      P_EAST:  step_x = SW'(1);
      P_WEST:  step_x = -SW'(1);
      P_NORTH: step_y = SW'(1);
      P_SOUTH: step_y = -SW'(1);
      default: ;
    endcase
  end

  always_comb begin
    hx = $signed({2'b00, here_x});
    hy = $signed({2'b00, here_y});
    tx = $signed({2'b00, dst_x});
    ty = $signed({2'b00, dst_y});
    ux = hx + step_x;
    uy = hy + step_y;
    dist_here_x = absdiff(tx, hx);
    dist_here_y = absdiff(ty, hy);
    dist_up_x   = absdiff(tx, ux);
    dist_up_y   = absdiff(ty, uy);
    approached  = (dist_here_x < dist_up_x) || (dist_here_y < dist_up_y);
  end
endmodule

// File: rtl/efv_enq_decode.sv
module efv_enq_decode
  import efv_pkg::*;
#(
  parameter int N = NPORTS
) (
  input  logic              fire,
  input  logic [PORT_W-1:0] target,
  input  logic [N-1:0]      mask,
  output logic [N-1:0]      strobe
);
  for (genvar p = 0; p < N; p++) begin : g_out
    assign strobe[p] = fire && (target == PORT_W'(p)) && !mask[p];
  end
endmodule

// File: rtl/eager_fwd_checker.sv
module eager_fwd_checker
  import efv_pkg::*;
#(
  parameter int PAYLOAD_W = 32,
  parameter int COORD_W   = 3,
  parameter int FLIT_W    = PAYLOAD_W + 2*COORD_W + 1
) (
  input  logic                 in_valid,
  input  logic [FLIT_W-1:0]    in_flit,
  input  logic [PORT_W-1:0]    in_port,
  input  logic                 in_fast,
  input  logic [NPORTS-1:0]    fast_mask,
  input  logic [COORD_W-1:0]   here_x,
  input  logic [COORD_W-1:0]   here_y,
  output logic                 keep,
  output logic                 drop,
  output logic [PORT_W-1:0]    out_port,
  output logic [NPORTS-1:0]    enq
);
  localparam int DX_LSB = PAYLOAD_W;
  localparam int DY_LSB = PAYLOAD_W + COORD_W;

  logic [COORD_W-1:0] dst_x, dst_y;
  port_e              route;
  logic               approached, turn_back, accept;

  assign dst_x = in_flit[DX_LSB +: COORD_W];
  assign dst_y = in_flit[DY_LSB +: COORD_W];

  efv_xy_route #(.COORD_W(COORD_W)) u_route (
    .here_x(here_x), .here_y(here_y), .dst_x(dst_x), .dst_y(dst_y), .route(route)
  );

  efv_progress #(.COORD_W(COORD_W)) u_prog (
    .here_x(here_x), .here_y(here_y), .dst_x(dst_x), .dst_y(dst_y),
    .arr_port(in_port), .approached(approached)
  );

  always_comb begin
    turn_back = (route == in_port);
    accept    = !turn_back && (!in_fast || approached);
    keep      = in_valid && accept;
    drop      = in_valid && !accept;
    out_port  = route;
  end

  efv_enq_decode #(.N(NPORTS)) u_enq (
    .fire(keep), .target(out_port), .mask(fast_mask), .strobe(enq)
  );

  always_comb begin
    a_r6_enq_onehot: assert ($onehot0(enq) || $isunknown(enq));
    if (in_valid === 1'b0) begin
      a_r7_idle_quiet: assert (!keep && !drop && enq == '0);
    end
    if (keep === 1'b1) begin
      a_r5_no_turn_back: assert (out_port != in_port);
    end
    if (in_valid === 1'b1 && in_fast === 1'b1 && approached === 1'b0) begin
      a_r4_dead_not_queued: assert (enq == '0 && drop);
    end
    a_r8_keep_drop_exclusive: assert (!(keep && drop) || $isunknown({keep, drop}));
  end
endmodule

// File: tb/eager_fwd_checker_tb.sv
module eager_fwd_checker_tb;
  logic        clk;
  logic        in_valid;
  logic [38:0] in_flit;
  logic [2:0]  in_port;
  logic        in_fast;
  logic [4:0]  fast_mask;
  logic [2:0]  here_x, here_y;
  logic        keep, drop;
  logic [2:0]  out_port;
  logic [4:0]  enq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  eager_fwd_checker u_dut (
    .in_valid(in_valid), .in_flit(in_flit), .in_port(in_port), .in_fast(in_fast),
    .fast_mask(fast_mask), .here_x(here_x), .here_y(here_y),
    .keep(keep), .drop(drop), .out_port(out_port), .enq(enq)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (here=%0d,%0d dst=%0d,%0d port=%0d fast=%0d mask=%0h)",
               req, act, exp, here_x, here_y, in_flit[34:32], in_flit[37:35], in_port, in_fast, fast_mask);
    end
  endtask

  function automatic int iabs(input int v);
    return v < 0 ? -v : v;
  endfunction

  task automatic apply(input int hx, input int hy, input int dx, input int dy,
                       input int prt, input int fst, input int msk, input int vld);
    int ep, ux, uy;
    bit appr, acc, ek;
    int een;
    @(negedge clk);
    here_x = 3'(hx); here_y = 3'(hy);
    in_flit = {1'b1, 3'(dy), 3'(dx), 32'hA5C3_0000 | 32'(dx*8+dy)};
    in_port = 3'(prt); in_fast = fst[0]; fast_mask = 5'(msk); in_valid = vld[0];
    #2;
    // R1: XY order
    if (dx > hx) ep = 1; else if (dx < hx) ep = 2;
    else if (dy > hy) ep = 3; else if (dy < hy) ep = 4; else ep = 0;
    ux = hx + (prt == 1 ? 1 : prt == 2 ? -1 : 0);
    uy = hy + (prt == 3 ? 1 : prt == 4 ? -1 : 0);
    appr = (iabs(dx-hx) < iabs(dx-ux)) || (iabs(dy-hy) < iabs(dy-uy));
    acc = (ep != prt) && (fst == 0 || appr);
    ek = vld[0] && acc;
    een = (ek && !msk[ep]) ? (1 << ep) : 0;
    check("R1", int'(out_port), ep);
    if (!vld[0]) begin
      check("R7", int'({keep, drop}), 0);
      check("R7", int'(enq), 0);
    end else begin
      if (ep == prt) check("R5", int'(keep), 0);
      else if (fst == 0) check("R2", int'(keep), 1);
      else if (appr) check("R3", int'(keep), 1);
      else begin
        check("R4", int'(keep), 0);
        check("R4", int'(enq), 0);
      end
      check("R8", int'(drop), int'(!ek));
      check("R6", int'(enq), een);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    in_valid = 0; in_flit = '0; in_port = '0; in_fast = 0; fast_mask = '0;
    here_x = '0; here_y = '0;
    // idle state: R7
    apply(3, 4, 5, 1, 1, 1, 0, 0);
    apply(0, 0, 0, 0, 0, 0, 0, 0);
    for (int s = 0; s < 3; s++) begin
      int hx, hy;
      hx = (s == 0) ? 0 : (s == 1) ? 3 : 7;
      hy = (s == 0) ? 0 : (s == 1) ? 4 : 7;
      for (int dx = 0; dx < 8; dx++)
        for (int dy = 0; dy < 8; dy++)
          for (int prt = 0; prt < 5; prt++)
            for (int fst = 0; fst < 2; fst++)
              apply(hx, hy, dx, dy, prt, fst, (dx*3 + dy + prt*7 + s) % 32 & 5'h15 ^ (fst ? 2 : 0), 1);
    end
    // R6: full mask suppresses all writes while keep stays set
    apply(3, 4, 6, 4, 2, 0, 31, 1);
    apply(3, 4, 3, 7, 0, 0, 31, 1);
    // R7: invalid sweep with fast flag
    for (int prt = 0; prt < 5; prt++) apply(2, 2, 5, 5, prt, 1, 0, 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule